// File: doc/BRIEF.md
# Execution Mask Save-and-Update Unit

This unit holds the 64-lane execution mask of a SIMD scalar core. Each accepted request carries one save-and-modify instruction. The unit hands back the mask as it stood before the instruction, so the old mask can be written to a destination register pair. It then overwrites the mask with a bitwise combination of a 64-bit source operand and that old mask. A condition flag reports whether any lane is still enabled.

Eight combining functions are supported:

- AND, OR and XOR of source and mask.
- Source AND inverted mask, and source OR inverted mask.
- NAND, NOR and XNOR of source and mask.

A parameter selects which of two opcode numbering schemes is decoded. An opcode outside the selected scheme leaves all state alone and raises an illegal-operation pulse.

Top module: `exec_mask_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the state is as follows: `exec_mask` is all ones, `cond_flag` is 1, `saved_mask` is 0 and `illegal_op` is 0.
- R2: `saved_mask` takes the value `exec_mask` had just before the clock edge of an accepted legal request. It is visible from that edge onward.
- R3: On the same edge, `exec_mask` becomes f(src, old mask). Operation index k selects f: 0 = s&m, 1 = s|m, 2 = s^m, 3 = s&~m, 4 = s|~m, 5 = ~(s&m), 6 = ~(s|m), 7 = ~(s^m).
- R4: `cond_flag` is 1 exactly when the updated `exec_mask` is non-zero, and 0 when it is all zeros.
- R5: With OPC_MAP=0, opcode 36+k selects operation k. With OPC_MAP=1, opcode 32+k selects operation k (k = 0..7).
- R6: An opcode outside the selected range drives `illegal_op` high for one cycle after the edge. `exec_mask`, `cond_flag` and `saved_mask` keep their values.
- R7: While `req_valid` is low, no output changes and `illegal_op` stays low.
- R8: Requests on consecutive cycles each save, and combine with, the mask left by the previous request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; the request executes on the rising edge |
| req_opcode | input | OPC_W (6) | Instruction opcode |
| req_src | input | MASK_W (64) | Source operand |
| saved_mask | output | MASK_W (64) | Mask value from before the last legal request |
| exec_mask | output | MASK_W (64) | Current execution mask |
| cond_flag | output | 1 | Set when the current mask is non-zero |
| illegal_op | output | 1 | One-cycle pulse after an unrecognised opcode |

## Verification
The assertions take for granted that `req_valid` and `req_opcode` are known, two-valued values at every rising edge once reset is released. They also assume that reset is held across at least one edge before requests start.

The bench drives inputs only on the falling edge and raises reset only after two edges. Its opcodes come from a fixed list of in-range and out-of-range values: the boundaries of both maps, plus values legal in one map but not in the other. It runs two instances, one per opcode map, from the same operation sequence.

// File: rtl/exm_pkg.sv
package exm_pkg;
   typedef enum logic [2:0] {
      OP_AND  = 3'd0,
      OP_OR   = 3'd1,
      OP_XOR  = 3'd2,
      OP_ANDN = 3'd3,
      OP_ORN  = 3'd4,
      OP_NAND = 3'd5,
      OP_NOR  = 3'd6,
      OP_XNOR = 3'd7
   } exm_op_e;
endpackage

// File: rtl/exm_decode.sv
module exm_decode #(
   parameter int OPC_W   = 6,
   parameter int OPC_MAP = 0
) (
   input  logic [OPC_W-1:0] opcode,
   output exm_pkg::exm_op_e kind,
   output logic             legal
);
   logic [OPC_W-1:0] base;
   logic [OPC_W-1:0] diff;

   generate
      if (OPC_W < 6) begin : g_bad_w
         $error("exm_decode: OPC_W must be at least 6");
      end
      if (OPC_MAP == 0) begin : g_map_old
         assign base = OPC_W'(36);
      end else if (OPC_MAP == 1) begin : g_map_new
         assign base = OPC_W'(32);
      end else begin : g_map_bad
         $error("exm_decode: OPC_MAP must be 0 or 1");
         assign base = '0;
      end
   endgenerate

   // A wrapped difference (opcode below base) has its high bits set.
   assign diff  = opcode - base;
   assign legal = (diff[OPC_W-1:3] == '0);
   assign kind  = exm_pkg::exm_op_e'(diff[2:0]);
endmodule

// File: rtl/exm_combine.sv
module exm_combine #(
   parameter int MASK_W = 64
) (
   input  exm_pkg::exm_op_e  kind,
   input  logic [MASK_W-1:0] src,
   input  logic [MASK_W-1:0] old_mask,
   output logic [MASK_W-1:0] new_mask
);
   always_comb begin
      unique case (kind)
         exm_pkg::OP_AND:  new_mask = src & old_mask;
         exm_pkg::OP_OR:   new_mask = src | old_mask;
         exm_pkg::OP_XOR:  new_mask = src ^ old_mask;
         exm_pkg::OP_ANDN: new_mask = src & ~old_mask;
         exm_pkg::OP_ORN:  new_mask = src | ~old_mask;
         exm_pkg::OP_NAND: new_mask = ~(src & old_mask);
         exm_pkg::OP_NOR:  new_mask = ~(src | old_mask);
         default:          new_mask = ~(src ^ old_mask);
      endcase
   end
endmodule

// File: rtl/exm_state.sv
module exm_state #(
   parameter int MASK_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              legal,
   input  logic [MASK_W-1:0] next_mask,
   output logic [MASK_W-1:0] mask_q,
   output logic [MASK_W-1:0] saved_q,
   output logic              flag_q,
   output logic              illegal_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q    <= '1;
         saved_q   <= '0;
         flag_q    <= 1'b1;
         illegal_q <= 1'b0;
      end else begin
         illegal_q <= valid && !legal;
         if (valid && legal) begin
            saved_q <= mask_q;
            mask_q  <= next_mask;
            flag_q  <= |next_mask;
         end
      end
   end

   // R2
   save_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && legal) |=> (saved_q == $past(mask_q)));
   // R4
   flag_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q == (mask_q != '0));
   // R6
   illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !legal) |=> (illegal_q && $stable(mask_q) && $stable(saved_q) && $stable(flag_q)));
   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> (!illegal_q && $stable(mask_q) && $stable(saved_q)));
endmodule

// File: rtl/exec_mask_unit.sv
module exec_mask_unit #(
   parameter int MASK_W  = 64,
   parameter int OPC_W   = 6,
   parameter int OPC_MAP = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [OPC_W-1:0]  req_opcode,
   input  logic [MASK_W-1:0] req_src,
   output logic [MASK_W-1:0] saved_mask,
   output logic [MASK_W-1:0] exec_mask,
   output logic              cond_flag,
   output logic              illegal_op
);
   generate
      if (MASK_W < 1) begin : g_bad_mask
         $error("exec_mask_unit: MASK_W must be positive");
      end
   endgenerate

   exm_pkg::exm_op_e  kind;
   logic              legal;
   logic [MASK_W-1:0] next_mask;

   exm_decode #(.OPC_W(OPC_W), .OPC_MAP(OPC_MAP)) u_dec (
      .opcode (req_opcode),
      .kind   (kind),
      .legal  (legal)
   );

   exm_combine #(.MASK_W(MASK_W)) u_comb (
      .kind     (kind),
      .src      (req_src),
      .old_mask (exec_mask),
      .new_mask (next_mask)
   );

   exm_state #(.MASK_W(MASK_W)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (req_valid),
      .legal     (legal),
      .next_mask (next_mask),
      .mask_q    (exec_mask),
      .saved_q   (saved_mask),
      .flag_q    (cond_flag),
      .illegal_q (illegal_op)
   );

   // R3
   and_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && legal && kind == exm_pkg::OP_AND) |=> ((exec_mask & ~$past(req_src)) == '0));
   // R1
   reset_mask_chk: assert property (@(posedge clk)
      $past(!rst_n) |-> (exec_mask == '1 && cond_flag && !illegal_op));
endmodule

// File: tb/test_exec_mask_unit.sv
module test_exec_mask_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [5:0]  opc_a = '0, opc_b = '0;
   logic [63:0] req_src = '0;
   logic [63:0] sav_a, msk_a, sav_b, msk_b;
   logic        flg_a, ill_a, flg_b, ill_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference state, per instance
   logic [63:0] m_msk[2], m_sav[2];
   logic        m_flg[2], m_ill[2];

   always #2.5 clk = ~clk;

   exec_mask_unit #(.OPC_MAP(0)) i_exec_mask_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(opc_a),
      .req_src(req_src), .saved_mask(sav_a), .exec_mask(msk_a),
      .cond_flag(flg_a), .illegal_op(ill_a));

   exec_mask_unit #(.OPC_MAP(1)) i_exec_mask_unit_b (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(opc_b),
      .req_src(req_src), .saved_mask(sav_b), .exec_mask(msk_b),
      .cond_flag(flg_b), .illegal_op(ill_b));

   function automatic logic [63:0] f_op(int k, logic [63:0] s, logic [63:0] m);
      case (k)
         0: return s & m;
         1: return s | m;
         2: return s ^ m;
         3: return s & ~m;
         4: return s | ~m;
         5: return ~(s & m);
         6: return ~(s | m);
         default: return ~(s ^ m);
      endcase
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all(string tag);
      chk({tag, " R3 R8 mask A"}, msk_a, m_msk[0]);
      chk({tag, " R2 saved A"}, sav_a, m_sav[0]);
      chk({tag, " R4 flag A"}, {63'd0, flg_a}, {63'd0, m_flg[0]});
      chk({tag, " R6 illegal A"}, {63'd0, ill_a}, {63'd0, m_ill[0]});
      chk({tag, " R5 mask B"}, msk_b, m_msk[1]);
      chk({tag, " R2 saved B"}, sav_b, m_sav[1]);
      chk({tag, " R4 flag B"}, {63'd0, flg_b}, {63'd0, m_flg[1]});
      chk({tag, " R6 illegal B"}, {63'd0, ill_b}, {63'd0, m_ill[1]});
   endtask

   task automatic model(int inst, bit v, int opc, logic [63:0] s);
      int base = (inst == 0) ? 36 : 32;
      bit lg = (opc >= base) && (opc <= base + 7);
      m_ill[inst] = v && !lg;
      if (v && lg) begin
         m_sav[inst] = m_msk[inst];
         m_msk[inst] = f_op(opc - base, s, m_msk[inst]);
         m_flg[inst] = (m_msk[inst] != 64'd0);
      end
   endtask

   // drive at negedge, model after the edge, compare at next negedge
   task automatic step(string tag, bit v, int oa, int ob, logic [63:0] s);
      req_valid = v;
      opc_a = 6'(oa);
      opc_b = 6'(ob);
      req_src = s;
      @(posedge clk);
      model(0, v, oa, s);
      model(1, v, ob, s);
      @(negedge clk);
      compare_all(tag);
   endtask

   initial begin
      for (int i = 0; i < 2; i++) begin
         m_msk[i] = '1; m_sav[i] = '0; m_flg[i] = 1'b1; m_ill[i] = 1'b0;
      end
      repeat (2) @(posedge clk);
      @(negedge clk);
      compare_all("R1 in reset");
      rst_n = 1'b1;
      step("R1 R7 idle after reset", 0, 36, 32, 64'hFFFF);
      // all eight operations, k = 0..7, in both maps
      step("R3 k0 AND", 1, 36, 32, 64'hF0F0_0000_1234_5678);
      step("R3 k1 OR", 1, 37, 33, 64'h0000_0000_0000_0F0F);
      step("R3 k2 XOR", 1, 38, 34, 64'hFFFF_0000_FFFF_0000);
      step("R3 k3 ANDN", 1, 39, 35, 64'hAAAA_5555_AAAA_5555);
      step("R3 k4 ORN", 1, 40, 36, 64'h0123_4567_89AB_CDEF);
      step("R3 k5 NAND", 1, 41, 37, 64'hDEAD_BEEF_CAFE_F00D);
      step("R3 k6 NOR", 1, 42, 38, 64'h0000_0000_FFFF_0000);
      step("R3 k7 XNOR", 1, 43, 39, 64'h1357_9BDF_2468_ACE0);
      // R4: drive mask to zero and back
      step("R4 AND zero", 1, 36, 32, 64'd0);
      step("R4 OR restore", 1, 37, 33, 64'h8000_0000_0000_0001);
      step("R4 XOR clear", 1, 38, 34, 64'h8000_0000_0000_0001);
      step("R4 NOR ones", 1, 42, 38, 64'd0);
      // R5/R6: boundary opcodes legal in one map and not the other
      step("R5 R6 old=32 new=40", 1, 32, 40, 64'h1);
      step("R5 R6 old=44 new=31", 1, 44, 31, 64'h2);
      step("R6 both zero", 1, 0, 0, 64'h3);
      step("R6 both 63", 1, 63, 63, 64'h4);
      step("R7 idle after illegal", 0, 44, 40, 64'h5);
      // R7: valid low with legal opcode does nothing
      step("R7 idle legal opc", 0, 36, 32, 64'd0);
      // R8: back-to-back pseudo-random sequence
      for (int n = 0; n < 200; n++) begin
         int k = $urandom_range(0, 9);
         logic [63:0] s = {$urandom, $urandom};
         step("R8 burst", (n % 7) != 6, 36 + k, 32 + k, s);
      end
      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=done");
      end
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule